// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO Port Controller

This block is a 36-bit FIFO whose write side (port A) and read side (port B) each run on their own clock. A port-A access stores a word only if the port is selected, set to the write direction, enabled, not addressed to the mailbox path, and the FIFO reports room. Port B uses the matching qualifiers, with its direction bit inverted, and the output-ready flag in place of input-ready. The oldest stored word is moved into an output register on its own as soon as the register is empty. Output-ready then means that the word on `b_dout` is valid, and a read consumes it.

Each side keeps a binary pointer and sends its Gray-coded copy to the other clock through a two-flop synchronizer. Each side computes its flags from its own pointer and the synchronized pointer of the other side. Almost-empty and almost-full are active low and are compared with the external offsets `x_ofs` and `y_ofs`. The top does not drive the data buses. It reports, through `a_oe` and `b_oe`, when the data bus of each port would be enabled. An asynchronous active-low reset clears both sides. Its release is synchronized separately into each clock.

The write side runs the state machine `WS_RESET -> WS_WAKE1 -> WS_WAKE2 -> WS_RUN`. The first arrow is taken on the first clock after the synchronized reset is released, and each later arrow is taken on the next clock. `WS_RUN` holds until the next reset. The read side has two states. `RS_EMPTY -> RS_HOLD` is taken when a word is available and the output register is empty. `RS_HOLD -> RS_EMPTY` is taken when a read consumes the held word and no further word is available. `RS_HOLD -> RS_HOLD` is taken on a read with a further word available, and that word is reloaded in the same clock.

Top module: `fwft_fifo36`

## Requirements
- R1: A word is stored on a rising `clk_a` edge only when `csa_n`=0, `mba`=0, `wra`=1, `ena`=1 and `in_rdy`=1. With any of these not met, nothing is stored.
- R2: A word is consumed on a rising `clk_b` edge only when `csb_n`=0, `mbb`=0, `wrb`=1, `enb`=1 and `out_rdy`=1. With any of these not met, `b_dout` and `out_rdy` are unchanged.
- R3: While `out_rdy`=0 and a word is stored, that word is loaded into the output register and `out_rdy` rises, with no read request.
- R4: Words leave on `b_dout` in the order they were written, and `b_dout` is the oldest unread word whenever `out_rdy`=1.
- R5: `a_oe` = 1 exactly when `csa_n`=0 and `wra`=0. `b_oe` = 1 exactly when `csb_n`=0 and `wrb`=1.
- R6: While `rst_n`=0: `in_rdy`=0, `out_rdy`=0, `aempty_n`=0 and `afull_n`=1. All stored words are discarded.
- R7: After `rst_n` rises, `in_rdy` stays low for at least two rising edges of `clk_a` and then rises.
- R8: With 2^AW (512) words stored, which counts the word held in the output register, `in_rdy`=0 and further writes are dropped.
- R9: `aempty_n`=0 whenever the stored count is at most `x_ofs`. When the FIFO is idle, `aempty_n`=1 exactly when the count exceeds `x_ofs`.
- R10: `afull_n`=0 whenever the free space (512 minus the count) is at most `y_ofs`. When the FIFO is idle, `afull_n`=1 exactly when the free space exceeds `y_ofs`.
- R11: Writes and reads on the two clocks may proceed in the same cycles without loss, duplication or reordering of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csa_n | input | 1 | Port A select, active low |
| wra | input | 1 | Port A direction, 1 = write |
| ena | input | 1 | Port A enable |
| mba | input | 1 | Port A mailbox select (1 = access not for the FIFO) |
| a_din | input | 36 | Write data |
| csb_n | input | 1 | Port B select, active low |
| wrb | input | 1 | Port B direction, 1 = read |
| enb | input | 1 | Port B enable |
| mbb | input | 1 | Port B mailbox select (1 = access not for the FIFO) |
| x_ofs | input | 10 | Almost-empty offset |
| y_ofs | input | 10 | Almost-full offset |
| b_dout | output | 36 | Head word from the output register |
| in_rdy | output | 1 | Room for a write |
| out_rdy | output | 1 | `b_dout` holds a valid word |
| aempty_n | output | 1 | Almost-empty, active low |
| afull_n | output | 1 | Almost-full, active low |
| a_oe | output | 1 | Port A data bus would be driven |
| b_oe | output | 1 | Port B data bus would be driven |

## Verification
The bench goes after the fall-through of the first word into an empty FIFO. A design that waited for a read request would leave `out_rdy` low with data stored. It also drops accesses with one qualifier off. A design that ignored `mba` or `enb` would store or consume a stray word, and the queue comparison against `b_dout` would show the shift. It fills the FIFO to exactly 512 words, counting the word in the output register, and sweeps the stored count across both offsets. An off-by-one in the full compare or in the flag compares then shows up as a wrong `in_rdy` or a wrong flag at the boundary count. Random, concurrent traffic on both clocks and a reset applied with data stored check that the Gray-coded pointer crossing neither loses nor repeats words, and that reset clears every flag.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
    typedef enum logic [1:0] {
        WS_RESET,
        WS_WAKE1,
        WS_WAKE2,
        WS_RUN
    } wr_state_e;

    typedef enum logic {
        RS_EMPTY,
        RS_HOLD
    } rd_state_e;
endpackage

// File: rtl/fwft_rst_sync.sv
module fwft_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stage_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage_q <= 1'b0;
            srst_n  <= 1'b0;
        end else begin
            stage_q <= 1'b1;
            srst_n  <= stage_q;
        end
    end
endmodule

// File: rtl/fwft_ptr_sync.sv
module fwft_ptr_sync #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_out[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl
    import fwft_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csa_n,
    input  logic          wra,
    input  logic          ena,
    input  logic          mba,
    input  logic [AW:0]   y_ofs,
    input  logic [AW:0]   ret_bin,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          in_rdy,
    output logic          afull_n
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    wr_state_e   state_q, state_d;
    logic [AW:0] wptr_q;
    logic [AW:0] wptr_nx;
    logic [AW:0] count_w;
    logic [AW:0] free_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_RESET: state_d = WS_WAKE1;
            WS_WAKE1: state_d = WS_WAKE2;
            WS_WAKE2: state_d = WS_RUN;
            WS_RUN:   state_d = WS_RUN;
        endcase
    end

    assign count_w = wptr_q - ret_bin;
    assign free_w  = FULL_CNT - count_w;

    always_comb begin
        in_rdy  = (state_q == WS_RUN) && (count_w != FULL_CNT);
        afull_n = (state_q != WS_RUN) || (free_w > y_ofs);
        wr_en   = !csa_n && !mba && wra && ena && in_rdy;
    end

    assign wptr_nx = wptr_q + {{AW{1'b0}}, wr_en};
    assign waddr   = wptr_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            wgray  <= '0;
        end else begin
            wptr_q <= wptr_nx;
            wgray  <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_w <= FULL_CNT);                                           // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count_w != '0));                                     // R1
    AST_AF_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WS_RUN) |-> (afull_n && !in_rdy));                  // R6
    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);                         // R11
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
    import fwft_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csb_n,
    input  logic          wrb,
    input  logic          enb,
    input  logic          mbb,
    input  logic [AW:0]   x_ofs,
    input  logic [AW:0]   wptr_bin,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          out_rdy,
    output logic          aempty_n
);
    rd_state_e   state_q, state_d;
    logic [AW:0] rptr_q;
    logic [AW:0] ret_q;
    logic [AW:0] ret_nx;
    logic [AW:0] avail;
    logic [AW:0] stored;
    logic        rd_en;
    logic        load;

    assign avail  = wptr_bin - rptr_q;
    assign stored = wptr_bin - ret_q;
    assign raddr  = rptr_q[AW-1:0];

    always_comb begin
        out_rdy  = (state_q == RS_HOLD);
        rd_en    = !csb_n && !mbb && wrb && enb && out_rdy;
        load     = (avail != '0) && (!out_rdy || rd_en);
        aempty_n = (stored > x_ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_EMPTY: if (load)           state_d = RS_HOLD;
            RS_HOLD:  if (rd_en && !load) state_d = RS_EMPTY;
        endcase
    end

    assign ret_nx = ret_q + {{AW{1'b0}}, rd_en};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
            ret_q  <= '0;
            rgray  <= '0;
            dout   <= '0;
        end else begin
            ret_q <= ret_nx;
            rgray <= ret_nx ^ (ret_nx >> 1);
            if (load) begin
                rptr_q <= rptr_q + 1'b1;
                dout   <= mem_q;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (stored != '0));                                      // R2
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && !rd_en) |=> ($stable(dout) && out_rdy));            // R2
    AST_FWFT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && avail != '0) |=> out_rdy);                         // R3
    AST_AE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (stored == '0) |-> !aempty_n);                                  // R9
endmodule

// File: rtl/fwft_fifo36.sv
module fwft_fifo36 #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          csa_n,
    input  logic          wra,
    input  logic          ena,
    input  logic          mba,
    input  logic [DW-1:0] a_din,
    input  logic          csb_n,
    input  logic          wrb,
    input  logic          enb,
    input  logic          mbb,
    input  logic [AW:0]   x_ofs,
    input  logic [AW:0]   y_ofs,
    output logic [DW-1:0] b_dout,
    output logic          in_rdy,
    output logic          out_rdy,
    output logic          aempty_n,
    output logic          afull_n,
    output logic          a_oe,
    output logic          b_oe
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic          rst_a_n, rst_b_n;
    logic          wr_en;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray;
    logic [PW-1:0] wptr_at_b, ret_at_a;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] mem [DEPTH];

    fwft_rst_sync u_rsa (.clk(clk_a), .arst_n(rst_n), .srst_n(rst_a_n));
    fwft_rst_sync u_rsb (.clk(clk_b), .arst_n(rst_n), .srst_n(rst_b_n));

    fwft_ptr_sync #(.PW(PW)) u_w2b (
        .clk(clk_b), .rst_n(rst_b_n), .gray_in(wgray), .bin_out(wptr_at_b));
    fwft_ptr_sync #(.PW(PW)) u_r2a (
        .clk(clk_a), .rst_n(rst_a_n), .gray_in(rgray), .bin_out(ret_at_a));

    fwft_wr_ctrl #(.AW(AW)) u_wr (
        .clk(clk_a), .rst_n(rst_a_n), .csa_n(csa_n), .wra(wra), .ena(ena),
        .mba(mba), .y_ofs(y_ofs), .ret_bin(ret_at_a), .wr_en(wr_en),
        .waddr(waddr), .wgray(wgray), .in_rdy(in_rdy), .afull_n(afull_n));

    fwft_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk_b), .rst_n(rst_b_n), .csb_n(csb_n), .wrb(wrb), .enb(enb),
        .mbb(mbb), .x_ofs(x_ofs), .wptr_bin(wptr_at_b), .mem_q(mem_q),
        .raddr(raddr), .rgray(rgray), .dout(b_dout), .out_rdy(out_rdy),
        .aempty_n(aempty_n));

    always_ff @(posedge clk_a) begin
        if (wr_en) mem[waddr] <= a_din;
    end

    assign mem_q = mem[raddr];
    assign a_oe  = !csa_n && !wra;
    assign b_oe  = !csb_n && wrb;

    AST_OE_EXCL_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        wr_en |-> !a_oe);                                               // R5
endmodule

// File: tb/sim_fwft_fifo36.sv
module sim_fwft_fifo36;
    localparam int AW = 9;
    localparam int DEPTH = 1 << AW;
    localparam int XO = 4;
    localparam int YO = 8;

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic csa_n = 1, wra = 0, ena = 0, mba = 0;
    logic csb_n = 1, wrb = 0, enb = 0, mbb = 0;
    logic [35:0] a_din = '0;
    logic [AW:0] x_ofs = AW'(XO), y_ofs = AW'(YO);
    logic [35:0] b_dout;
    logic in_rdy, out_rdy, aempty_n, afull_n, a_oe, b_oe;

    int total = 0, bad = 0;
    logic [35:0] q[$];
    logic [35:0] wcount = 36'h100;
    bit live = 0;

    always #4 clk_a = ~clk_a;
    always #5.5 clk_b = ~clk_b;

    fwft_fifo36 u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: queue of unread words
    always @(posedge clk_a)
        if (rst_n && !csa_n && !mba && wra && ena && in_rdy) q.push_back(a_din);
    always @(posedge clk_b)
        if (rst_n && !csb_n && !mbb && wrb && enb && out_rdy && q.size() > 0) void'(q.pop_front());
    always @(negedge rst_n) q.delete();

    // per-clock comparisons
    always @(negedge clk_b) if (live && rst_n) begin
        if (out_rdy) begin
            chk(q.size() > 0, "R3", 64'(q.size()), 1);
            if (q.size() > 0) chk(b_dout == q[0], "R4", b_dout, q[0]);
        end
        if (q.size() <= XO) chk(!aempty_n, "R9", aempty_n, 0);
    end
    always @(negedge clk_a) if (live && rst_n) begin
        if (in_rdy) chk(q.size() < DEPTH, "R8", 64'(q.size()), DEPTH - 1);
        if (DEPTH - q.size() <= YO) chk(!afull_n, "R10", afull_n, 0);
    end

    task automatic wr_cyc(input logic [35:0] d, input logic cs, input logic dir, input logic en, input logic mb);
        @(negedge clk_a);
        csa_n = cs; wra = dir; ena = en; mba = mb; a_din = d;
        @(posedge clk_a);
    endtask
    task automatic idle_a();
        @(negedge clk_a); csa_n = 1; ena = 0; wra = 0; mba = 0;
    endtask
    task automatic rd_cyc(input logic cs, input logic dir, input logic en, input logic mb);
        @(negedge clk_b);
        csb_n = cs; wrb = dir; enb = en; mbb = mb;
        @(posedge clk_b);
    endtask
    task automatic idle_b();
        @(negedge clk_b); csb_n = 1; enb = 0; wrb = 0; mbb = 0;
    endtask
    task automatic put(input int n);
        for (int i = 0; i < n; i++) begin
            wcount++;
            wr_cyc(wcount, 0, 1, 1, 0);
        end
        idle_a();
    endtask
    task automatic take(input int n);
        for (int i = 0; i < n; i++) rd_cyc(0, 1, 1, 0);
        idle_b();
    endtask
    task automatic settle_exact(input string tag);
        repeat (12) @(negedge clk_b);
        chk(out_rdy == (q.size() > 0), "R3", out_rdy, q.size() > 0);
        chk(aempty_n == (q.size() > XO), "R9", aempty_n, q.size() > XO);
        chk(afull_n == ((DEPTH - q.size()) > YO), "R10", afull_n, (DEPTH - q.size()) > YO);
        chk(in_rdy == (q.size() < DEPTH), "R8", in_rdy, q.size() < DEPTH);
        if (out_rdy && q.size() > 0) chk(b_dout == q[0], {"R4 ", tag}, b_dout, q[0]);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int edges;
        logic [35:0] held;
        // R6: flags while reset is held
        repeat (6) @(posedge clk_a);
        #1;
        chk(!in_rdy, "R6", in_rdy, 0);
        chk(!out_rdy, "R6", out_rdy, 0);
        chk(!aempty_n, "R6", aempty_n, 0);
        chk(afull_n, "R6", afull_n, 1);
        // R7: wake-up sequence
        @(negedge clk_a); rst_n = 1;
        repeat (2) @(posedge clk_a);
        #1 chk(!in_rdy, "R7", in_rdy, 0);
        edges = 2;
        while (!in_rdy && edges < 20) begin @(posedge clk_a); #1; edges++; end
        chk(in_rdy, "R7", in_rdy, 1);
        live = 1;

        // R5: output-enable decode
        @(negedge clk_a);
        csa_n = 0; wra = 0; csb_n = 0; wrb = 1; #1;
        chk(a_oe && b_oe, "R5", {a_oe, b_oe}, 2'b11);
        wra = 1; wrb = 0; #1;
        chk(!a_oe && !b_oe, "R5", {a_oe, b_oe}, 2'b00);
        csa_n = 1; wra = 0; csb_n = 1; wrb = 1; #1;
        chk(!a_oe && !b_oe, "R5", {a_oe, b_oe}, 2'b00);
        csa_n = 1; wra = 0; csb_n = 1; wrb = 0;

        // R1: disqualified writes are dropped
        wr_cyc(36'hBAD1, 0, 1, 0, 0);
        wr_cyc(36'hBAD2, 1, 1, 1, 0);
        wr_cyc(36'hBAD3, 0, 1, 1, 1);
        wr_cyc(36'hBAD4, 0, 0, 1, 0);
        idle_a();
        repeat (12) @(negedge clk_b);
        chk(!out_rdy, "R1", out_rdy, 0);

        // R3: first word falls through without a read
        put(1);
        settle_exact("R3");
        chk(out_rdy && b_dout == 36'h101, "R3", b_dout, 36'h101);

        // R2: disqualified reads leave the head in place
        held = b_dout;
        rd_cyc(0, 1, 0, 0);
        rd_cyc(1, 1, 1, 0);
        rd_cyc(0, 1, 1, 1);
        rd_cyc(0, 0, 1, 0);
        idle_b();
        repeat (3) @(negedge clk_b);
        chk(out_rdy && b_dout == held, "R2", b_dout, held);

        // R4: ordered burst
        put(10);
        take(6);
        settle_exact("R4");
        take(5);
        settle_exact("R4");

        // R9 boundary around x_ofs
        put(XO);
        settle_exact("R9 at X");
        put(1);
        settle_exact("R9 at X+1");
        take(5);
        settle_exact("R9 empty");

        // R8 / R10: fill to the brim
        for (int i = 0; i < DEPTH - YO - 1; i++) begin wcount++; wr_cyc(wcount, 0, 1, 1, 0); end
        idle_a();
        settle_exact("R10 free Y+1");
        put(1);
        settle_exact("R10 free Y");
        put(YO + 3);
        settle_exact("R8 full");
        chk(!in_rdy && q.size() == DEPTH, "R8", 64'(q.size()), DEPTH);
        take(DEPTH);
        settle_exact("R8 drained");

        // R11: concurrent random traffic
        fork
            for (int i = 0; i < 400; i++) begin
                wcount++;
                wr_cyc(wcount, 0, 1, 1'($urandom), 0);
            end
            for (int i = 0; i < 400; i++) rd_cyc(0, 1, 1'($urandom), 0);
        join
        idle_a(); idle_b();
        settle_exact("R11");
        take(q.size() + 2);
        settle_exact("R11 drained");
        chk(q.size() == 0 && !out_rdy, "R11", out_rdy, 0);

        // R6: reset with data present
        put(7);
        repeat (12) @(negedge clk_b);
        live = 0;
        rst_n = 0;
        #1;
        chk(!in_rdy && !out_rdy, "R6", {in_rdy, out_rdy}, 0);
        chk(!aempty_n && afull_n, "R6", {aempty_n, afull_n}, 2'b01);
        repeat (6) @(posedge clk_b);
        @(negedge clk_a); rst_n = 1;
        repeat (20) @(posedge clk_a);
        live = 1;
        settle_exact("R6 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule